// File: doc/BRIEF.md
# Peripheral Response Wait Scheduler

This block sits in the transmit path of a display serial link host. Each time the host finishes sending a packet, it reports the packet's 6-bit data type and whether the packet went out in high-speed or low-power mode. A separate strobe reports each bus turn-around. The block sorts each event into one of three classes: read request, write request or turn-around. It then picks the wait time that applies to that class and speed mode, from five programmable 16-bit timeouts.

While a wait is running, the block raises `link_hold`. The transmit scheduler uses this signal to keep the lanes idle in the stop state and to send nothing, even when packets are queued. At the start of a wait, the block issues a one-cycle request for the lanes to enter the stop state. The wait counter advances only in cycles where the `tick` clock enable is high. When the wait ends, the block emits a one-cycle done pulse. A synchronous clear aborts any wait that is running.

Events arrive as plain one-cycle strobes and are not flow controlled. No back-pressure applies at this edge: the only throttling mechanism is `link_hold`, which the scheduler must honour. An event that arrives while a wait is already running is dropped.

Top module: `resp_wait_sched`

## Requirements
- R1: Data types 0x04, 0x14, 0x24 and 0x06 form the read class. They wait for `tmo_rd_hs` when `pkt_hs`=1 and for `tmo_rd_lp` when `pkt_hs`=0.
- R2: Data types 0x03, 0x13, 0x23, 0x29, 0x05, 0x15, 0x39 and 0x37 form the write class. They wait for `tmo_wr_hs` when `pkt_hs`=1 and for `tmo_wr_lp` when `pkt_hs`=0.
- R3: A `bta_sent` strobe waits for `tmo_bta` whatever the value of `pkt_hs`. If a packet strobe arrives in the same cycle, the turn-around takes precedence.
- R4: A data type outside both classes, or a class whose selected timeout is zero, starts no wait. In that case `link_hold`, `stop_req` and `wait_done` all stay low.
- R5: An accepted event raises `link_hold` in the next cycle. In that same cycle, `stop_req` is high for exactly one cycle.
- R6: For a selected timeout L, the counter steps once per cycle with `tick` high. `link_hold` stays high through the cycle in which the count equals L and falls in the cycle after it. With `tick` held high, the hold therefore lasts L+1 cycles. With `tick` low, the hold never ends.
- R7: `wait_done` is high for exactly one cycle: the first cycle in which `link_hold` is low after a completed wait.
- R8: A packet or turn-around strobe that arrives while `link_hold` is high is ignored. The running wait keeps its original length.
- R9: `clr` drops `link_hold` in the next cycle without a `wait_done` pulse. A trigger that arrives in the same cycle as `clr` is discarded.
- R10: After reset, `link_hold`, `stop_req` and `wait_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous abort of any running wait |
| tick | input | 1 | Timeout counter clock enable |
| pkt_sent | input | 1 | One-cycle strobe: a packet was sent |
| pkt_dtype | input | 6 | Data type of the sent packet |
| pkt_hs | input | 1 | 1 = packet sent in high-speed mode, 0 = low-power mode |
| bta_sent | input | 1 | One-cycle strobe: a bus turn-around was issued |
| tmo_bta | input | 16 | Turn-around wait, in ticks |
| tmo_rd_hs | input | 16 | Read wait for high-speed packets |
| tmo_rd_lp | input | 16 | Read wait for low-power packets |
| tmo_wr_hs | input | 16 | Write wait for high-speed packets |
| tmo_wr_lp | input | 16 | Write wait for low-power packets |
| link_hold | output | 1 | Blocks transmission; lanes are kept in the stop state |
| stop_req | output | 1 | One-cycle request for the lanes to enter the stop state |
| wait_done | output | 1 | One-cycle pulse when a wait completes |

## Verification
Two events can fall in the same cycle: a new trigger and the synchronous clear. This can happen while the block is idle or while a wait is running.

The bench provokes both cases. It pulses `clr` together with a read strobe while idle, and then together with a write strobe in the middle of a wait. It judges the result at the ports: the cycle after must show `link_hold`, `stop_req` and `wait_done` all low.

The bench also checks that a fresh event accepted afterwards produces a full-length hold. A second collision, a turn-around arriving together with a packet, must give the turn-around's length.

// File: rtl/resp_wait_pkg.sv
package resp_wait_pkg;
  localparam int DT_W = 6;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_BTA   = 2'd1,
    EV_READ  = 2'd2,
    EV_WRITE = 2'd3
  } ev_class_e;
endpackage

// File: rtl/resp_class_dec.sv
module resp_class_dec
  import resp_wait_pkg::*;
(
  input  logic [DT_W-1:0] dtype,
  output ev_class_e       cls
);
  always_comb begin
    unique case (dtype)
      6'h04, 6'h14, 6'h24, 6'h06:                      cls = EV_READ;
      6'h03, 6'h13, 6'h23, 6'h29,
      6'h05, 6'h15, 6'h39, 6'h37:                      cls = EV_WRITE;
      default:                                         cls = EV_NONE;
    endcase
  end
endmodule

// File: rtl/resp_tmo_sel.sv
module resp_tmo_sel
  import resp_wait_pkg::*;
#(
  parameter int TW = 16
) (
  input  ev_class_e   cls,
  input  logic        hs,
  input  logic [TW-1:0] t_bta,
  input  logic [TW-1:0] t_rd_hs,
  input  logic [TW-1:0] t_rd_lp,
  input  logic [TW-1:0] t_wr_hs,
  input  logic [TW-1:0] t_wr_lp,
  output logic [TW-1:0] limit
);
  always_comb begin
    unique case (cls)
      EV_BTA:   limit = t_bta;
      EV_READ:  limit = hs ? t_rd_hs : t_rd_lp;
      EV_WRITE: limit = hs ? t_wr_hs : t_wr_lp;
      default:  limit = '0;
    endcase
  end
endmodule

// File: rtl/resp_wait_ctr.sv
module resp_wait_ctr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          start,
  input  logic [TW-1:0] limit_in,
  output logic          active,
  output logic          done,
  output logic          stop_pulse
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim_q;
  logic          accept;
  logic          reached;

  assign accept  = start && !active && !clr && (limit_in != '0);
  assign reached = active && (cnt_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      done       <= 1'b0;
      stop_pulse <= 1'b0;
      cnt_q      <= '0;
      lim_q      <= '0;
    end else begin
      done       <= 1'b0;
      stop_pulse <= 1'b0;
      if (clr) begin
        active <= 1'b0;
        cnt_q  <= '0;
      end else if (accept) begin
        active     <= 1'b1;
        stop_pulse <= 1'b1;
        cnt_q      <= '0;
        lim_q      <= limit_in;
      end else if (reached) begin
        active <= 1'b0;
        done   <= 1'b1;
      end else if (active && tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= lim_q)) else $error("count passed limit"); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !clr && !reached) |=> (active && $stable(cnt_q))) else $error("count moved without tick"); // R6
  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (lim_q != '0)) else $error("zero wait started"); // R4
  AST_CLR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!active && !done && !stop_pulse)) else $error("clear did not abort"); // R9
endmodule

// File: rtl/resp_wait_sched.sv
module resp_wait_sched
  import resp_wait_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick,
  input  logic            pkt_sent,
  input  logic [DT_W-1:0] pkt_dtype,
  input  logic            pkt_hs,
  input  logic            bta_sent,
  input  logic [TW-1:0]   tmo_bta,
  input  logic [TW-1:0]   tmo_rd_hs,
  input  logic [TW-1:0]   tmo_rd_lp,
  input  logic [TW-1:0]   tmo_wr_hs,
  input  logic [TW-1:0]   tmo_wr_lp,
  output logic            link_hold,
  output logic            stop_req,
  output logic            wait_done
);
  ev_class_e     dec_cls;
  ev_class_e     ev_cls;
  logic [TW-1:0] sel_limit;

  resp_class_dec u_dec (
    .dtype (pkt_dtype),
    .cls   (dec_cls)
  );

  always_comb begin
    if (bta_sent)      ev_cls = EV_BTA;
    else if (pkt_sent) ev_cls = dec_cls;
    else               ev_cls = EV_NONE;
  end

  resp_tmo_sel #(.TW(TW)) u_sel (
    .cls     (ev_cls),
    .hs      (pkt_hs),
    .t_bta   (tmo_bta),
    .t_rd_hs (tmo_rd_hs),
    .t_rd_lp (tmo_rd_lp),
    .t_wr_hs (tmo_wr_hs),
    .t_wr_lp (tmo_wr_lp),
    .limit   (sel_limit)
  );

  resp_wait_ctr #(.TW(TW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .tick       (tick),
    .start      (ev_cls != EV_NONE),
    .limit_in   (sel_limit),
    .active     (link_hold),
    .done       (wait_done),
    .stop_pulse (stop_req)
  );

  AST_HOLD_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_hold) |-> stop_req) else $error("hold rose without stop request"); // R5
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req) else $error("stop request longer than a cycle"); // R5
  AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |-> (!link_hold && $past(link_hold))) else $error("done not at hold end"); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (link_hold && (pkt_sent || bta_sent)) |=> !stop_req) else $error("event accepted while busy"); // R8
endmodule

// File: tb/resp_wait_sched_test.sv
module resp_wait_sched_test;
  localparam int TW = 16;
  localparam int T_BTA = 3, T_RDH = 5, T_RDL = 7, T_WRH = 2, T_WRL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, tick = 1'b1, pkt_sent = 1'b0, pkt_hs = 1'b0, bta_sent = 1'b0;
  logic [5:0] pkt_dtype = '0;
  logic [TW-1:0] tmo_bta = T_BTA, tmo_rd_hs = T_RDH, tmo_rd_lp = T_RDL;
  logic [TW-1:0] tmo_wr_hs = T_WRH, tmo_wr_lp = T_WRL;
  logic link_hold, stop_req, wait_done;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  resp_wait_sched #(.TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .pkt_sent(pkt_sent), .pkt_dtype(pkt_dtype), .pkt_hs(pkt_hs), .bta_sent(bta_sent),
    .tmo_bta(tmo_bta), .tmo_rd_hs(tmo_rd_hs), .tmo_rd_lp(tmo_rd_lp),
    .tmo_wr_hs(tmo_wr_hs), .tmo_wr_lp(tmo_wr_lp),
    .link_hold(link_hold), .stop_req(stop_req), .wait_done(wait_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [5:0] dt, input logic hs);
    case (dt)
      6'h04, 6'h14, 6'h24, 6'h06: return hs ? int'(tmo_rd_hs) : int'(tmo_rd_lp);
      6'h03, 6'h13, 6'h23, 6'h29, 6'h05, 6'h15, 6'h39, 6'h37:
        return hs ? int'(tmo_wr_hs) : int'(tmo_wr_lp);
      default: return 0;
    endcase
  endfunction

  // Drive one trigger, then measure the hold, the stop pulse and the done pulse.
  task automatic run_event(input bit is_bta, input bit is_pkt, input logic [5:0] dt,
                           input logic hs, input int exp, input string req);
    int n;
    pkt_sent = is_pkt; bta_sent = is_bta; pkt_dtype = dt; pkt_hs = hs;
    @(negedge clk);
    pkt_sent = 1'b0; bta_sent = 1'b0;
    chk(link_hold == (exp > 0), req, link_hold, exp > 0);
    chk(stop_req == (exp > 0), req, stop_req, exp > 0);
    n = 0;
    while (link_hold && n < 100) begin
      n++;
      @(negedge clk);
      if (link_hold) chk(!stop_req, "R5", stop_req, 0);
    end
    chk(n == ((exp > 0) ? exp + 1 : 0), req, n, (exp > 0) ? exp + 1 : 0);
    chk(wait_done == (exp > 0), "R7", wait_done, exp > 0);
    @(negedge clk);
    chk(!wait_done && !link_hold, "R7", wait_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!link_hold && !stop_req && !wait_done, "R10", {link_hold, stop_req, wait_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4: full sweep of data types and speed modes
    for (int d = 0; d < 64; d++) begin
      for (int h = 0; h < 2; h++) begin
        run_event(1'b0, 1'b1, d[5:0], h[0], exp_len(d[5:0], h[0]), "R1/R2/R4 sweep");
      end
    end

    // R3: turn-around length independent of speed flag, and priority over packets
    run_event(1'b1, 1'b0, 6'h00, 1'b0, T_BTA, "R3");
    run_event(1'b1, 1'b0, 6'h00, 1'b1, T_BTA, "R3");
    run_event(1'b1, 1'b1, 6'h24, 1'b0, T_BTA, "R3 priority");

    // R4: zero timeout starts nothing
    tmo_rd_hs = '0;
    run_event(1'b0, 1'b1, 6'h06, 1'b1, 0, "R4 zero");
    tmo_rd_hs = T_RDH;

    // R6: stall with tick low, then resume
    tick = 1'b0;
    pkt_sent = 1'b1; pkt_dtype = 6'h29; pkt_hs = 1'b0;
    @(negedge clk);
    pkt_sent = 1'b0;
    repeat (20) @(negedge clk);
    chk(link_hold && !wait_done, "R6 stall", link_hold, 1);
    tick = 1'b1;
    repeat (T_WRL) @(negedge clk);
    chk(link_hold, "R6 resume", link_hold, 1);
    @(negedge clk);
    chk(!link_hold && wait_done, "R6 end", link_hold, 0);
    @(negedge clk);

    // R8: retrigger mid wait is ignored
    pkt_sent = 1'b1; pkt_dtype = 6'h14; pkt_hs = 1'b0;
    @(negedge clk);
    pkt_sent = 1'b0;
    repeat (3) @(negedge clk);
    bta_sent = 1'b1; pkt_sent = 1'b1; pkt_dtype = 6'h39;
    @(negedge clk);
    bta_sent = 1'b0; pkt_sent = 1'b0;
    chk(!stop_req, "R8", stop_req, 0);
    repeat (T_RDL - 4) @(negedge clk);
    chk(link_hold, "R8 length", link_hold, 1);
    @(negedge clk);
    chk(!link_hold && wait_done, "R8 length", link_hold, 0);
    @(negedge clk);

    // R9: clear with trigger while idle
    clr = 1'b1; pkt_sent = 1'b1; pkt_dtype = 6'h04; pkt_hs = 1'b1;
    @(negedge clk);
    clr = 1'b0; pkt_sent = 1'b0;
    chk(!link_hold && !stop_req && !wait_done, "R9 idle clr", link_hold, 0);
    // R9: clear with trigger mid wait
    pkt_sent = 1'b1; pkt_dtype = 6'h24; pkt_hs = 1'b0;
    @(negedge clk);
    pkt_sent = 1'b0;
    repeat (2) @(negedge clk);
    clr = 1'b1; pkt_sent = 1'b1; pkt_dtype = 6'h13; pkt_hs = 1'b1;
    @(negedge clk);
    clr = 1'b0; pkt_sent = 1'b0;
    chk(!link_hold && !stop_req && !wait_done, "R9 busy clr", link_hold, 0);
    repeat (10) begin
      @(negedge clk);
      chk(!wait_done && !link_hold, "R9 no done", wait_done, 0);
    end
    run_event(1'b0, 1'b1, 6'h37, 1'b1, T_WRH, "R9 after clr");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule